// File: doc/BRIEF.md
# Pattern-Skipping Scan Self-Test Controller

This controller sequences a test-per-scan self-test session. A pattern index walks through a fixed-length sequence of pseudo-random patterns. For every index the controller steps the pattern generator once per scan cell, so the generator sequence stays the same whichever patterns are used. A compile-time bitmask says which indices are worth applying. For a useful index the chain shifts and the response compactor is enabled while the pattern loads, and a single capture pulse follows. For a useless index the chain and compactor stay still and no capture is issued. The chain therefore makes no transitions for patterns that detect no new faults.

A one-cycle start request begins a session from the idle or finished state. A finished flag rises after the last index has been handled. It stays high until a reset or a new start request arrives. Generator contents, scan cells and signature logic sit outside this block. The controller drives only their enables.

Top module: `scan_skip_bist_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no start request, all enables (generator advance, chain shift, compactor enable, capture) are low, the finished flag is low and the pattern index is 0.
- R2: A high start request sampled in the idle or finished state begins a session in the next cycle with pattern index 0. A start request during a running session has no effect on any output.
- R3: A pattern is useful when bit i of USEFUL_MASK is 1, where i is the pattern index (bit 0 is pattern 0). Patterns are visited in ascending index order, 0 through NUM_PATTERNS-1.
- R4: For a useful pattern, the generator advance, chain shift and compactor enable are high together for exactly CHAIN_LEN consecutive cycles, with capture low and the index equal to the pattern number.
- R5: Right after those CHAIN_LEN cycles comes exactly one cycle with capture high and the generator advance, chain shift and compactor enable low. The index then moves to the next pattern in the following cycle, unless this was the last pattern.
- R6: For a useless pattern, the generator advance is high for exactly CHAIN_LEN cycles while the chain shift, compactor enable and capture stay low. No capture cycle follows, and the next pattern begins at once.
- R7: Once the last pattern completes, the finished flag is high with all enables low and the index held at NUM_PATTERNS-1. This holds until reset or a new start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Session start request |
| tpg_adv_o | output | 1 | Pattern generator step enable |
| chain_shift_o | output | 1 | Scan chain shift enable |
| compact_en_o | output | 1 | Response compactor enable |
| capture_o | output | 1 | System-mode capture pulse |
| done_o | output | 1 | Session finished flag |
| pat_idx_o | output | IDX_W | Current pattern index |

## Verification
The default mask contains a leading useful pattern, two useless patterns in a row, isolated useless patterns and a useful last pattern. The bench checks that a skipped pattern neither shifts the chain nor captures, and that it still steps the generator for the full chain length. An off-by-one shift counter would show up as a run of CHAIN_LEN±1 shift cycles. A controller that captured on skipped patterns would show an extra capture pulse. Start pulses injected at random points mid-session must leave every output unchanged, since a design that honoured them would jump back to pattern 0. The bench also checks that a reset in the middle of a session returns the block to idle, and that a restart from the finished state replays the whole schedule.

// File: rtl/scan_skip_bist_pkg.sv
package scan_skip_bist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SHIFT   = 3'd1,
    ST_CAPTURE = 3'd2,
    ST_SKIP    = 3'd3,
    ST_DONE    = 3'd4
  } bist_state_e;

  // Width of a counter able to hold the values 0 .. n-1.
  function automatic int unsigned cnt_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/scan_skip_pat_counter.sv
module scan_skip_pat_counter #(
  parameter int unsigned NUM_PATTERNS = 12,
  localparam int unsigned IDX_W = scan_skip_bist_pkg::cnt_width(NUM_PATTERNS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W-1:0] idx_nxt_o,
  output logic             last_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PATTERNS - 1);

  logic [IDX_W-1:0] idx_q;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] v);
    return (v == LAST_IDX) ? v : v + IDX_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) idx_q <= '0;
    else if (step_i)       idx_q <= bump(idx_q);
  end

  assign idx_o     = idx_q;
  assign idx_nxt_o = bump(idx_q);
  assign last_o    = (idx_q == LAST_IDX);

endmodule

// File: rtl/scan_skip_shift_counter.sv
module scan_skip_shift_counter #(
  parameter int unsigned CHAIN_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);

  localparam int unsigned SH_W = scan_skip_bist_pkg::cnt_width(CHAIN_LEN);
  localparam logic [SH_W-1:0] LAST_CNT = SH_W'(CHAIN_LEN - 1);

  logic [SH_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i)     cnt_q <= '0;
    else if (cnt_q == LAST_CNT) cnt_q <= '0;
    else                      cnt_q <= cnt_q + SH_W'(1);
  end

  assign last_o = run_i && (cnt_q == LAST_CNT);

endmodule

// File: rtl/scan_skip_useful_dec.sv
module scan_skip_useful_dec #(
  parameter int unsigned NUM_PATTERNS = 12,
  parameter logic [NUM_PATTERNS-1:0] USEFUL_MASK = '1,
  localparam int unsigned IDX_W = scan_skip_bist_pkg::cnt_width(NUM_PATTERNS)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             useful_o
);

  function automatic logic pattern_useful(input logic [IDX_W-1:0] idx);
    logic hit;
    hit = 1'b0;
    for (int unsigned k = 0; k < NUM_PATTERNS; k++) begin
      if (32'(idx) == k) hit = USEFUL_MASK[k];
    end
    return hit;
  endfunction

  assign useful_o = pattern_useful(idx_i);

endmodule

// File: rtl/scan_skip_bist_ctrl.sv
module scan_skip_bist_ctrl #(
  parameter int unsigned CHAIN_LEN    = 6,
  parameter int unsigned NUM_PATTERNS = 12,
  parameter logic [NUM_PATTERNS-1:0] USEFUL_MASK = 12'b1010_0110_1101,
  localparam int unsigned IDX_W = scan_skip_bist_pkg::cnt_width(NUM_PATTERNS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             tpg_adv_o,
  output logic             chain_shift_o,
  output logic             compact_en_o,
  output logic             capture_o,
  output logic             done_o,
  output logic [IDX_W-1:0] pat_idx_o
);

  import scan_skip_bist_pkg::*;

  bist_state_e state_q, state_d;

  // Named internal events
  logic             at_rest;
  logic             session_go;
  logic             shift_last;
  logic             pat_last;
  logic             pat_step;
  logic             next_useful;
  logic             load_phase;
  logic [IDX_W-1:0] idx_cur;
  logic [IDX_W-1:0] idx_nxt;
  logic [IDX_W-1:0] dec_idx;

  assign at_rest    = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign session_go = at_rest && start_i;
  assign load_phase = (state_q == ST_SHIFT) || (state_q == ST_SKIP);
  assign pat_step   = !pat_last &&
                      ((state_q == ST_CAPTURE) ||
                       ((state_q == ST_SKIP) && shift_last));
  // At rest the next pattern is pattern 0; otherwise it is the successor.
  assign dec_idx    = at_rest ? '0 : idx_nxt;

  scan_skip_pat_counter #(.NUM_PATTERNS(NUM_PATTERNS)) u_pat_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (session_go),
    .step_i    (pat_step),
    .idx_o     (idx_cur),
    .idx_nxt_o (idx_nxt),
    .last_o    (pat_last)
  );

  scan_skip_shift_counter #(.CHAIN_LEN(CHAIN_LEN)) u_sh_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (load_phase),
    .last_o (shift_last)
  );

  scan_skip_useful_dec #(
    .NUM_PATTERNS (NUM_PATTERNS),
    .USEFUL_MASK  (USEFUL_MASK)
  ) u_dec (
    .idx_i    (dec_idx),
    .useful_o (next_useful)
  );

  function automatic bist_state_e load_state(input logic useful);
    return useful ? ST_SHIFT : ST_SKIP;
  endfunction

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) state_d = load_state(next_useful);
      ST_SHIFT:         if (shift_last) state_d = ST_CAPTURE;
      ST_CAPTURE:       state_d = pat_last ? ST_DONE : load_state(next_useful);
      ST_SKIP: begin
        if (shift_last) state_d = pat_last ? ST_DONE : load_state(next_useful);
      end
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign tpg_adv_o     = load_phase;
  assign chain_shift_o = (state_q == ST_SHIFT);
  assign compact_en_o  = (state_q == ST_SHIFT);
  assign capture_o     = (state_q == ST_CAPTURE);
  assign done_o        = (state_q == ST_DONE);
  assign pat_idx_o     = idx_cur;

endmodule

// File: rtl/scan_skip_bist_chk.sv
module scan_skip_bist_chk #(
  parameter int unsigned CHAIN_LEN    = 6,
  parameter int unsigned NUM_PATTERNS = 12,
  parameter logic [NUM_PATTERNS-1:0] USEFUL_MASK = '1,
  localparam int unsigned IDX_W = scan_skip_bist_pkg::cnt_width(NUM_PATTERNS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             tpg_adv_o,
  input logic             chain_shift_o,
  input logic             compact_en_o,
  input logic             capture_o,
  input logic             done_o,
  input logic [IDX_W-1:0] pat_idx_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PATTERNS - 1);

  int unsigned      shift_run;
  int unsigned      adv_run;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_run <= 0;
      adv_run   <= 0;
      idx_q     <= '0;
    end else begin
      shift_run <= chain_shift_o ? shift_run + 1 : 0;
      adv_run   <= (pat_idx_o != idx_q) ? 32'(tpg_adv_o) : adv_run + 32'(tpg_adv_o);
      idx_q     <= pat_idx_o;
    end
  end

  // R3: shifting only happens on indices marked useful
  a_r3_shift_on_useful: assert property (@(posedge clk) disable iff (!rst_n)
    chain_shift_o |-> USEFUL_MASK[pat_idx_o]);

  // R4: compactor runs together with the chain
  a_r4_compact_with_shift: assert property (@(posedge clk) disable iff (!rst_n)
    compact_en_o |-> (chain_shift_o && tpg_adv_o));

  // R5: capture follows exactly CHAIN_LEN shift cycles
  a_r5_capture_after_full_load: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |-> (shift_run == CHAIN_LEN && !tpg_adv_o));

  // R5: index advances after a non-final capture
  a_r5_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_o && pat_idx_o != LAST_IDX) |=> (pat_idx_o == $past(pat_idx_o) + IDX_W'(1)));

  // R6: every pattern index steps the generator CHAIN_LEN times
  a_r6_adv_per_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_idx_o != idx_q) |-> (adv_run == CHAIN_LEN));

  // R7: finished state is quiet
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!tpg_adv_o && !chain_shift_o && !capture_o && pat_idx_o == LAST_IDX));

  // R7: finished state holds without a start request
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  // R1: at most one activity kind per cycle
  a_r1_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tpg_adv_o, capture_o, done_o}));

endmodule

bind scan_skip_bist_ctrl scan_skip_bist_chk #(
  .CHAIN_LEN    (CHAIN_LEN),
  .NUM_PATTERNS (NUM_PATTERNS),
  .USEFUL_MASK  (USEFUL_MASK)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .tpg_adv_o     (tpg_adv_o),
  .chain_shift_o (chain_shift_o),
  .compact_en_o  (compact_en_o),
  .capture_o     (capture_o),
  .done_o        (done_o),
  .pat_idx_o     (pat_idx_o)
);

// File: tb/scan_skip_bist_ctrl_tb.sv
module scan_skip_bist_ctrl_tb_top;

  localparam int unsigned CHAIN_LEN    = 6;
  localparam int unsigned NUM_PATTERNS = 12;
  localparam logic [NUM_PATTERNS-1:0] MASK = 12'b1010_0110_1101;
  localparam int unsigned IDX_W = (NUM_PATTERNS > 1) ? $clog2(NUM_PATTERNS) : 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic tpg_adv_o, chain_shift_o, compact_en_o, capture_o, done_o;
  logic [IDX_W-1:0] pat_idx_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  scan_skip_bist_ctrl #(
    .CHAIN_LEN    (CHAIN_LEN),
    .NUM_PATTERNS (NUM_PATTERNS),
    .USEFUL_MASK  (MASK)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .tpg_adv_o     (tpg_adv_o),
    .chain_shift_o (chain_shift_o),
    .compact_en_o  (compact_en_o),
    .capture_o     (capture_o),
    .done_o        (done_o),
    .pat_idx_o     (pat_idx_o)
  );

  // Expected output vector {adv, shift, compact, capture, done}
  // kind: 0 = load of useful pattern, 1 = capture, 2 = skipped load, 3 = rest, 4 = finished
  function automatic logic [4:0] expect_vec(input int kind);
    case (kind)
      0: return 5'b11100;
      1: return 5'b00010;
      2: return 5'b10000;
      4: return 5'b00001;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic int session_len();
    int n = 0;
    for (int p = 0; p < NUM_PATTERNS; p++) n += CHAIN_LEN + (MASK[p] ? 1 : 0);
    return n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_cycle(input string req, input int kind, input int idx);
    chk(req, int'({tpg_adv_o, chain_shift_o, compact_en_o, capture_o, done_o}),
        int'(expect_vec(kind)));
    chk(req, int'(pat_idx_o), idx);
  endtask

  // Runs one whole session; pulse_at >= 0 raises start during that session cycle.
  // abort_at >= 0 applies reset at that cycle and returns.
  task automatic run_session(input int pulse_at, input int abort_at);
    int cyc = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int p = 0; p < NUM_PATTERNS; p++) begin
      for (int s = 0; s <= CHAIN_LEN; s++) begin
        if (s == CHAIN_LEN && !MASK[p]) break;
        if (cyc == abort_at) begin
          rst_n = 1'b0;
          @(negedge clk);
          chk_cycle("R1 reset mid-session", 3, 0);
          rst_n = 1'b1;
          @(negedge clk);
          chk_cycle("R1 idle after reset", 3, 0);
          return;
        end
        if (s == CHAIN_LEN)  chk_cycle("R5 capture", 1, p);
        else if (MASK[p])    chk_cycle("R4 useful load", 0, p);
        else                 chk_cycle("R6 skipped load", 2, p);
        start_i = (cyc == pulse_at);
        cyc++;
        @(negedge clk);
        start_i = 1'b0;
      end
    end
    chk_cycle("R7 finished", 4, NUM_PATTERNS - 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int total;
    int gap;
    void'($urandom(32'h5eed_0b15));
    total = session_len();

    repeat (3) @(negedge clk);
    chk_cycle("R1 in reset", 3, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_cycle("R1 idle no start", 3, 0);

    // Directed: clean session (R2 R3 R4 R5 R6 R7)
    run_session(-1, -1);
    repeat (5) begin
      @(negedge clk);
      chk_cycle("R7 finished holds", 4, NUM_PATTERNS - 1);
    end

    // Directed: start ignored right at session start and just before the end (R2)
    run_session(0, -1);
    run_session(total - 2, -1);

    // Directed: reset in the middle of a session (R1)
    run_session(-1, total / 2);
    run_session(-1, -1);

    // Random sessions: random idle gaps, random mid-session start pulses, random aborts
    for (int k = 0; k < 10; k++) begin
      gap = int'($urandom_range(0, 6));
      repeat (gap) begin
        @(negedge clk);
        chk("R7 finished holds in gap", int'(done_o), 1);
      end
      if ($urandom_range(0, 4) == 0)
        run_session(-1, int'($urandom_range(1, total - 2)));
      else
        run_session(int'($urandom_range(0, total - 2)), -1);
      if (!done_o) run_session(-1, -1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule